// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital sequencer of a successive-approximation analog-to-digital converter with a processor-style read interface. A read cycle with the byte select low launches a conversion. The controller then holds a sample phase long enough for the input to settle. After that it walks a trial code down the DAC, one bit per clock, from the top bit to bit zero. At each step it keeps or drops the trial bit according to a single comparator bit. When the last bit is decided, the whole code goes into an output latch in one step.

The result is read over a shared data bus. It is driven only while chip select and read are both low; otherwise only an output-enable flag is modelled. With the byte select low, the whole word appears. With it high, only the top nibble moves down to the low lines. A narrow host therefore reads the low byte during the read that starts the next conversion, and the upper part with a second read that has the byte select high. Any start request made while a conversion runs is ignored. The analog front end is outside the block, and the comparator arrives as one input bit.

Top module: `sar_conv_ctrl`

## Requirements
- R1: An active-low reset (asserted asynchronously, released after two clock edges) returns the controller to idle with busy low and with both the approximation register and the output latch cleared.
- R2: A conversion starts when cs_n and rd_n become both low (a fresh assertion) while hben is low and the controller is idle; busy is high from the next cycle on.
- R3: busy stays high for exactly SAMPLE_CYC + WIDTH cycles. SAMPLE_CYC = ceil(CLK_MHZ * SAMPLE_NS / 1000), at least 1, which is 200 for the defaults.
- R4: During the first SAMPLE_CYC busy cycles, dac_code is zero. In busy cycle SAMPLE_CYC + k, dac_code has bit WIDTH-1-k set and every bit below it clear.
- R5: comp_hi = 1 means the trial code exceeds the input, and the trial bit is then cleared; with comp_hi = 0 it is kept. With an ideal comparator the result equals the input code.
- R6: The output latch does not change while busy is high. A read that starts a conversion returns the previous result.
- R7: Start requests made while busy is high are ignored and do not lengthen or restart the conversion.
- R8: The output latch takes the new result in the same clock edge at which busy falls.
- R9: data_oe is high exactly when cs_n and rd_n are both low. While data_oe is low, data_out is all zeros.
- R10: While driven with hben = 0, data_out carries the full 12-bit result. With hben = 1, data_out[3:0] carries result bits 11..8 and data_out[11:4] is zero.
- R11: A read with hben = 1 never starts a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| hben | input | 1 | High-byte select for the read; must be low to start |
| comp_hi | input | 1 | Comparator decision: trial code is above the input |
| busy | output | 1 | Conversion in progress |
| dac_code | output | 12 | Trial code to the DAC |
| data_out | output | 12 | Read data |
| data_oe | output | 1 | Data bus driven |

## Verification
A start strobe sampled at an edge makes busy visible one cycle later. The bench therefore checks busy at the falling edge after the strobe and then counts falling edges with busy high, expecting SAMPLE_CYC + WIDTH of them. Within that count the trial code is due at count SAMPLE_CYC + 1 for the top bit and at the last count for bit zero, and the bench samples it at exactly those points. The read data is combinational from the latch, so it is checked one time step after the strobe is driven in the same cycle; a conversion's result becomes readable in the first idle cycle.

// File: rtl/conv_pkg.sv
package conv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SAMPLE  = 2'd1,
    ST_CONVERT = 2'd2
  } conv_state_e;
endpackage

// File: rtl/conv_rst_sync.sv
module conv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shift_q[STAGES-1];
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_pkg::*;
#(
  parameter int WIDTH      = 12,
  parameter int SAMPLE_CYC = 200
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel,
  input  logic                     hben,
  output logic                     busy,
  output logic                     sar_clr,
  output logic                     step,
  output logic [$clog2(WIDTH)-1:0] bit_idx
);
  localparam int CNT_W = $clog2(SAMPLE_CYC + 1);
  localparam int IDX_W = $clog2(WIDTH);

  conv_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             sel_q;
  logic             start_req;

  // fresh select edge with the low byte chosen
  assign start_req = sel && !sel_q && !hben;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sar_clr = 1'b0;
    step    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_req) begin
          state_d = ST_SAMPLE;
          cnt_d   = '0;
          sar_clr = 1'b1;
        end
      end
      ST_SAMPLE: begin
        if (cnt_q == CNT_W'(SAMPLE_CYC - 1)) begin
          state_d = ST_CONVERT;
          idx_d   = IDX_W'(WIDTH - 1);
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CONVERT: begin
        step = 1'b1;
        if (idx_q == '0) state_d = ST_IDLE;
        else             idx_d   = idx_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel;
      if (state_q != ST_IDLE || start_req) cnt_q <= cnt_d;
      if (state_q != ST_IDLE)              idx_q <= idx_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign bit_idx = idx_q;
endmodule

// File: rtl/conv_sar.sv
module conv_sar #(
  parameter int WIDTH = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     step,
  input  logic [$clog2(WIDTH)-1:0] bit_idx,
  input  logic                     comp_hi,
  output logic [WIDTH-1:0]         dac_code,
  output logic [WIDTH-1:0]         result
);
  logic [WIDTH-1:0] sar_q, sar_d;
  logic [WIDTH-1:0] lat_q, lat_d;
  logic [WIDTH-1:0] trial;
  logic [WIDTH-1:0] decided;
  logic             last;

  assign trial   = WIDTH'(1) << bit_idx;
  assign decided = comp_hi ? (sar_q & ~trial) : (sar_q | trial);
  assign last    = step && (bit_idx == '0);

  always_comb begin
    sar_d = sar_q;
    if (clr)       sar_d = '0;
    else if (step) sar_d = decided;
    lat_d = last ? decided : lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q <= '0;
      lat_q <= '0;
    end else begin
      if (clr || step) sar_q <= sar_d;
      if (last)        lat_q <= lat_d;
    end
  end

  assign dac_code = step ? (sar_q | trial) : sar_q;
  assign result   = lat_q;
endmodule

// File: rtl/conv_bus.sv
module conv_bus #(
  parameter int WIDTH  = 12,
  parameter int BYTE_W = 8
) (
  input  logic             sel,
  input  logic             hben,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] data_out,
  output logic             data_oe
);
  logic [WIDTH-1:0] hi_part;

  assign hi_part  = word >> BYTE_W;
  assign data_oe  = sel;
  assign data_out = !sel ? '0 : (hben ? hi_part : word);
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int WIDTH     = 12,
  parameter int BYTE_W    = 8,
  parameter int CLK_MHZ   = 200,
  parameter int SAMPLE_NS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             hben,
  input  logic             comp_hi,
  output logic             busy,
  output logic [WIDTH-1:0] dac_code,
  output logic [WIDTH-1:0] data_out,
  output logic             data_oe
);
  localparam int SAMPLE_RAW = (CLK_MHZ * SAMPLE_NS + 999) / 1000;
  localparam int SAMPLE_CYC = (SAMPLE_RAW < 1) ? 1 : SAMPLE_RAW;
  localparam int IDX_W      = $clog2(WIDTH);

  logic             rst_core_n;
  logic             sel;
  logic             sar_clr;
  logic             step;
  logic [IDX_W-1:0] bit_idx;
  logic [WIDTH-1:0] latch_word;

  assign sel = !cs_n && !rd_n;

  conv_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  conv_seq #(.WIDTH(WIDTH), .SAMPLE_CYC(SAMPLE_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .sel     (sel),
    .hben    (hben),
    .busy    (busy),
    .sar_clr (sar_clr),
    .step    (step),
    .bit_idx (bit_idx)
  );

  conv_sar #(.WIDTH(WIDTH)) u_sar (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr      (sar_clr),
    .step     (step),
    .bit_idx  (bit_idx),
    .comp_hi  (comp_hi),
    .dac_code (dac_code),
    .result   (latch_word)
  );

  conv_bus #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_bus (
    .sel      (sel),
    .hben     (hben),
    .word     (latch_word),
    .data_out (data_out),
    .data_oe  (data_oe)
  );
endmodule

// File: rtl/conv_chk.sv
module conv_chk #(
  parameter int WIDTH      = 12,
  parameter int BYTE_W     = 8,
  parameter int SAMPLE_CYC = 200
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             rd_n,
  input logic             hben,
  input logic             busy,
  input logic [WIDTH-1:0] dac_code,
  input logic [WIDTH-1:0] data_out,
  input logic             data_oe,
  input logic [WIDTH-1:0] result
);
  localparam int TOTAL = SAMPLE_CYC + WIDTH;
  localparam int BW    = $clog2(TOTAL + 2);
  localparam int HI_W  = WIDTH - BYTE_W;

  logic [BW-1:0]    bcnt;
  logic [BW-1:0]    pos;
  logic [WIDTH-1:0] below;
  logic             in_conv;
  logic             trial_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  assign in_conv  = busy && (bcnt >= BW'(SAMPLE_CYC));
  assign pos      = BW'(TOTAL - 1) - bcnt;
  assign below    = (WIDTH'(1) << pos) - 1'b1;
  assign trial_ok = ((dac_code >> pos) & WIDTH'(1)) != '0 && (dac_code & below) == '0;

  AST_START_COND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!cs_n && !rd_n && !hben)); // R2
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (bcnt == BW'(TOTAL))); // R3
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bcnt < BW'(TOTAL - 1)) |=> busy); // R7
  AST_SAMPLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bcnt < BW'(SAMPLE_CYC)) |-> dac_code == '0); // R4
  AST_TRIAL_POS: assert property (@(posedge clk) disable iff (!rst_n)
    in_conv |-> trial_ok); // R4
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $stable(result)); // R6
  AST_LATCH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $fell(busy)); // R8
  AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> data_out == '0); // R9
  AST_BUS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe == (!cs_n && !rd_n)); // R9
  AST_HI_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && hben) |-> (data_out == (result >> BYTE_W))); // R10
  AST_HI_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && !hben) |-> (data_out == result)); // R10

  initial assert (HI_W > 0); // R10
endmodule

bind sar_conv_ctrl conv_chk #(
  .WIDTH(WIDTH), .BYTE_W(BYTE_W), .SAMPLE_CYC(SAMPLE_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
  .busy(busy), .dac_code(dac_code), .data_out(data_out), .data_oe(data_oe),
  .result(latch_word)
);

// File: tb/sim_sar_conv_ctrl.sv
`timescale 1ns/1ps
module sim_sar_conv_ctrl;
  localparam int W     = 12;
  localparam int SCYC  = 4;   // 200 MHz, 20 ns sample phase
  localparam int TOTAL = SCYC + W;

  logic          clk = 1'b0;
  logic          rst_n, cs_n, rd_n, hben;
  logic          comp_hi, busy, data_oe;
  logic [W-1:0]  dac_code, data_out;
  int            target;
  int            prev;
  int            n_chk = 0;
  int            n_err = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  // ideal comparator
  assign comp_hi = (int'(dac_code) > target);

  sar_conv_ctrl #(.WIDTH(W), .BYTE_W(8), .CLK_MHZ(200), .SAMPLE_NS(20)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
    .comp_hi(comp_hi), .busy(busy), .dac_code(dac_code),
    .data_out(data_out), .data_oe(data_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // read the upper part with hben high; must not start a conversion
  task automatic read_hi(input int exp_word);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; hben = 1'b1;
    #1;
    chk("R9 oe during read", int'(data_oe), 1);
    chk("R10 high nibble", int'(data_out), exp_word >> 8);
    @(negedge clk);
    chk("R11 no start on hben read", int'(busy), 0);
    cs_n = 1'b1; rd_n = 1'b1; hben = 1'b0;
    #1;
    chk("R9 bus idle", int'(data_out), 0);
  endtask

  task automatic convert(input int tv, input bit again);
    int n;
    @(negedge clk);
    target = tv;
    cs_n = 1'b0; rd_n = 1'b0; hben = 1'b0;
    #1;
    chk("R6 previous word on start read", int'(data_out), prev);
    @(negedge clk);
    chk("R2 busy after start", int'(busy), 1);
    cs_n = 1'b1; rd_n = 1'b1;
    n = 0;
    while (busy === 1'b1 && n < 40) begin
      n++;
      cs_n = 1'b1; rd_n = 1'b1; hben = 1'b0;
      if (n <= SCYC) begin
        if (n == 2) chk("R4 zero code in sample", int'(dac_code), 0);
      end
      if (n == SCYC + 1) chk("R4 MSB trial first", int'(dac_code), 1 << (W - 1));
      if (n == TOTAL) chk("R4 LSB trial last", int'(dac_code), tv | 1);
      if (again && n == 6) begin
        cs_n = 1'b0; rd_n = 1'b0;   // R7 restart attempt
      end
      if (n == 10) begin
        cs_n = 1'b0; rd_n = 1'b0; hben = 1'b1;
        #1;
        chk("R6 latch held during conversion", int'(data_out), prev >> 8);
      end
      @(negedge clk);
    end
    cs_n = 1'b1; rd_n = 1'b1; hben = 1'b0;
    chk("R3 R7 busy length", n, TOTAL);
    read_hi(tv);
    prev = tv;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R3 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; hben = 1'b0;
    target = 0; prev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 R9 oe idle", int'(data_oe), 0);
    chk("R1 R9 bus zero", int'(data_out), 0);
    read_hi(0);

    // near-exhaustive sweep of input codes, restart attempts on odd steps
    for (int t = 0; t < 4096 + 7; t += 7) begin
      convert((t > 4095) ? 4095 : t, (t % 2) == 1);
    end
    convert(2048, 1'b0);
    convert(2047, 1'b1);
    convert(1, 1'b0);
    // R5 full word check of the last result via a start read
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; hben = 1'b0;
    #1;
    chk("R5 R10 full word", int'(data_out), 1);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset in mid-conversion
    rst_n = 1'b0;
    #1;
    chk("R1 busy cleared by reset", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy idle after reset", int'(busy), 0);
    read_hi(0);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; hben = 1'b0;
    #1;
    chk("R1 latch cleared", int'(data_out), 0);
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    repeat (TOTAL + 2) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule